// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects single-cycle event pulses from fourteen peripheral sources and turns them into one level-sensitive interrupt request line for a CPU. The sources are vertical blank, horizontal blank, vertical line match, four timer overflows, a serial port, four DMA completions, the keypad and cartridge insertion or removal. Each peripheral also supplies an arm level, which is its own local enable for that event. An event pulse that arrives while its arm level is high is stored in a pending-flag register.

Software works through a small register bus with three registers. The first holds one controller-side enable bit per source. The second holds the pending flags. A bit in this register is cleared by writing a 1 to it and is left alone by writing a 0. The third register holds a single master enable bit. The request line is high when the master bit is set and at least one source has both its enable bit and its pending flag set. Software finds the cause by reading the pending flags. There is no priority encoding and no vector output.

Top module: `irq_gather`

## Requirements
- R1: An event pulse on `src_ev[i]` sets pending flag i only if `src_arm[i]` is high in the same cycle. When `src_arm[i]` is low, the pulse leaves the flags unchanged.
- R2: `irq` stays low while the master enable bit is 0, whatever the enable and flag values. A pending flag whose enable bit is 0 does not raise `irq`.
- R3: An armed event pulse sets its flag at the next clock edge. The flag bits are fixed: bit 0 vertical blank, 1 horizontal blank, 2 line match, 3 to 6 timers 0 to 3, 7 serial, 8 to 11 DMA 0 to 3, 12 keypad, 13 cartridge.
- R4: A bus write to the flag register (address 1) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: `irq` is registered. It equals master AND (OR of enable AND flags) as those registers stood one cycle earlier, so it changes one clock after a flag or enable update.
- R6: If an armed event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: Register map, word addressed on `bus_addr`: 0 is the enable register (read/write), 1 is the flag register, 2 is the master register (bit 0), and 3 reads as zero and ignores writes. `bus_rdata` is combinational from `bus_addr`.
- R8: Bits 15:14 of the enable and flag registers always read as 0. Bits 15:1 of the master register always read as 0, whatever value is written.
- R9: While `rst_n` is low, all enables, flags and the master bit are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ev | input | 14 | One-cycle event pulses, one per source |
| src_arm | input | 14 | Peripheral-side enable level for each source |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that the bus and event inputs are clean, synchronous levels that are sampled at each rising edge. They also assume that a write strobe lasts exactly one cycle per intended write, because a held strobe would repeat the clear. The bench changes every input only on the falling edge. It raises `bus_wr` for one cycle at a time and then drops it before it checks the read-back. It deliberately overlaps an event and a clear on one bit to exercise the set-wins case.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int N_SRC  = 14;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 2'd0,
    RA_FLAGS  = 2'd1,
    RA_MASTER = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  // Flag bit positions; software decodes these, so the order is fixed.
  localparam int SRC_VBLANK  = 0;
  localparam int SRC_HBLANK  = 1;
  localparam int SRC_LINEHIT = 2;
  localparam int SRC_TIMER0  = 3;
  localparam int SRC_SERIAL  = 7;
  localparam int SRC_DMA0    = 8;
  localparam int SRC_KEYPAD  = 12;
  localparam int SRC_CART    = 13;
endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int N = 14
) (
  input  logic [N-1:0] ev,
  input  logic [N-1:0] arm,
  output logic [N-1:0] hit
);
  // Each source is qualified by its own peripheral-side arm level.
  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit[g] = ev[g] & arm[g];
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[g] <= 1'b0;
      else if (hit[g])
        pend[g] <= 1'b1;               // set beats a same-cycle clear
      else if (clr_stb && clr_mask[g])
        pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_gather_pkg::*;
#(
  parameter int N     = N_SRC,
  parameter int W     = REG_W,
  parameter int AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  en_q,
  output logic          master_q,
  output logic          flag_clr_stb,
  output logic [N-1:0]  flag_clr_mask,
  output logic [W-1:0]  bus_rdata
);
  localparam int PAD = W - N;

  reg_addr_e sel;
  assign sel = reg_addr_e'(bus_addr);

  logic wr_en, wr_master;
  assign wr_en     = bus_wr && (sel == RA_ENABLE);
  assign wr_master = bus_wr && (sel == RA_MASTER);

  assign flag_clr_stb  = bus_wr && (sel == RA_FLAGS);
  assign flag_clr_mask = bus_wdata[N-1:0];

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[W-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      if (wr_en)     en_q     <= bus_wdata[N-1:0];
      if (wr_master) master_q <= bus_wdata[0];
    end
  end

  always_comb begin
    unique case (sel)
      RA_ENABLE: bus_rdata = {{PAD{1'b0}}, en_q};
      RA_FLAGS:  bus_rdata = {{PAD{1'b0}}, pend};
      RA_MASTER: bus_rdata = {{(W-1){1'b0}}, master_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] pend,
  input  logic         master,
  output logic         irq
);
  logic any_live;
  assign any_live = |(en & pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= master & any_live;
  end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_ev,
  input  logic [N_SRC-1:0]  src_arm,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [N_SRC-1:0] hit_w, pend_w, en_w, clr_mask_w;
  logic             master_w, clr_stb_w;

  irq_src_gate #(.N(N_SRC)) u_gate (
    .ev(src_ev), .arm(src_arm), .hit(hit_w)
  );

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit_w),
    .clr_stb(clr_stb_w), .clr_mask(clr_mask_w), .pend(pend_w)
  );

  irq_ctrl_regs #(.N(N_SRC), .W(REG_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(pend_w), .en_q(en_w), .master_q(master_w),
    .flag_clr_stb(clr_stb_w), .flag_clr_mask(clr_mask_w), .bus_rdata(bus_rdata)
  );

  irq_line_drv #(.N(N_SRC)) u_line (
    .clk(clk), .rst_n(rst_n), .en(en_w), .pend(pend_w),
    .master(master_w), .irq(irq)
  );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
  import irq_gather_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_ev,
  input logic [N_SRC-1:0]  src_arm,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              irq,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  en,
  input logic              master
);
  logic [N_SRC-1:0] armed, clr;
  assign armed = src_ev & src_arm;
  assign clr   = (bus_wr && bus_addr == 2'd1) ? bus_wdata[N_SRC-1:0] : '0;

  // R3 / R6: an armed event always leaves its flag set
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(armed)) == $past(armed));

  // R1 / R4: untouched flags hold
  a_r4_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(armed | clr)) == ($past(pend) & ~$past(armed | clr)));

  // R4: cleared flags drop unless an armed event set them
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(clr & ~armed)) == '0);

  // R5: registered request line
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(master && ((en & pend) != '0)));

  // R2: no request without master enable
  a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(master) |-> !irq);

  // R8: unused read bits are zero
  a_r8_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[REG_W-1:N_SRC] == '0);
endmodule

bind irq_gather irq_gather_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_ev(src_ev), .src_arm(src_arm),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .pend(pend_w), .en(en_w),
  .master(master_w)
);

// File: tb/test_irq_gather.sv
module test_irq_gather;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [13:0] ev;
    logic [13:0] arm;
    logic [1:0]  raddr;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 16'h0001, 14'h0000, 14'h3FFF, 2'd0, 16'h0001, 1'b0, 4'd7}, // R7 enable write
    '{1'b1, 2'd2, 16'h0001, 14'h0000, 14'h3FFF, 2'd2, 16'h0001, 1'b0, 4'd7}, // R7 master write
    '{1'b0, 2'd0, 16'h0000, 14'h0001, 14'h3FFF, 2'd1, 16'h0001, 1'b1, 4'd3}, // R3 vblank bit 0
    '{1'b1, 2'd1, 16'h0001, 14'h0000, 14'h3FFF, 2'd1, 16'h0000, 1'b0, 4'd4}, // R4 clear
    '{1'b0, 2'd0, 16'h0000, 14'h0020, 14'h3FFF, 2'd1, 16'h0020, 1'b0, 4'd2}, // R2 flag w/o enable
    '{1'b1, 2'd0, 16'h0021, 14'h0000, 14'h3FFF, 2'd0, 16'h0021, 1'b1, 4'd5}, // R5 enable raises
    '{1'b1, 2'd2, 16'h0000, 14'h0000, 14'h3FFF, 2'd2, 16'h0000, 1'b0, 4'd2}, // R2 master off
    '{1'b1, 2'd2, 16'h0003, 14'h0000, 14'h3FFF, 2'd2, 16'h0001, 1'b1, 4'd8}, // R8 master bit 0 only
    '{1'b1, 2'd1, 16'h0000, 14'h0000, 14'h3FFF, 2'd1, 16'h0020, 1'b1, 4'd4}, // R4 zero write keeps
    '{1'b0, 2'd0, 16'h0000, 14'h2000, 14'h1FFF, 2'd1, 16'h0020, 1'b1, 4'd1}, // R1 disarmed source
    '{1'b1, 2'd0, 16'hFFFF, 14'h0000, 14'h3FFF, 2'd0, 16'h3FFF, 1'b1, 4'd8}, // R8 enable upper bits
    '{1'b1, 2'd1, 16'hFFFF, 14'h0000, 14'h3FFF, 2'd1, 16'h0000, 1'b0, 4'd4}, // R4 clear all
    '{1'b0, 2'd0, 16'h0000, 14'h3FFF, 14'h3FFF, 2'd1, 16'h3FFF, 1'b1, 4'd3}, // R3 all sources
    '{1'b1, 2'd1, 16'h3FFF, 14'h0000, 14'h3FFF, 2'd1, 16'h0000, 1'b0, 4'd4}, // R4 clear all
    '{1'b1, 2'd3, 16'hFFFF, 14'h0000, 14'h3FFF, 2'd3, 16'h0000, 1'b0, 4'd7}  // R7 spare address
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_ev = '0, src_arm = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_gather i_irq_gather (
    .clk(clk), .rst_n(rst_n), .src_ev(src_ev), .src_arm(src_arm),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic drive(input logic wr, input logic [1:0] a, input logic [15:0] d,
                       input logic [13:0] ev, input logic [13:0] arm);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_ev = ev; src_arm = arm;
    @(negedge clk);
    bus_wr = 1'b0; src_ev = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    read_chk("R9 enable at reset", 2'd0, 16'h0000);
    read_chk("R9 flags at reset", 2'd1, 16'h0000);
    read_chk("R9 master at reset", 2'd2, 16'h0000);
    check("R9 irq at reset", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].ev, VEC[i].arm);
      bus_addr = VEC[i].raddr;
      @(negedge clk);
      checks++;
      if (bus_rdata !== VEC[i].exp_rd) begin
        fails++;
        $display("FAIL vec %0d R%0d rdata: got %h expected %h", i, VEC[i].req, bus_rdata, VEC[i].exp_rd);
      end
      checks++;
      if (irq !== VEC[i].exp_irq) begin
        fails++;
        $display("FAIL vec %0d R%0d irq: got %b expected %b", i, VEC[i].req, irq, VEC[i].exp_irq);
      end
    end

    // R6: set and clear on bit 2 in the same cycle
    drive(1'b1, 2'd0, 16'h3FFF, '0, 14'h3FFF);
    drive(1'b1, 2'd2, 16'h0001, '0, 14'h3FFF);
    drive(1'b1, 2'd1, 16'h0004, 14'h0004, 14'h3FFF);
    @(negedge clk);
    read_chk("R6 set wins", 2'd1, 16'h0004);
    check("R6 irq after collision", {15'd0, irq}, 16'h0001);
    drive(1'b1, 2'd1, 16'h0004, '0, 14'h3FFF);
    @(negedge clk);
    read_chk("R4 clear after collision", 2'd1, 16'h0000);

    // R5: one-cycle latency from flag to irq (DMA0 bit 8)
    @(negedge clk);
    src_ev = 14'h0100; src_arm = 14'h3FFF;
    @(negedge clk);
    src_ev = '0;
    read_chk("R5 flag set first", 2'd1, 16'h0100);
    check("R5 irq not yet", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R5 irq next cycle", {15'd0, irq}, 16'h0001);

    // R9: reset in mid-run clears everything
    rst_n = 1'b0;
    #1;
    check("R9 irq in reset", {15'd0, irq}, 16'h0000);
    read_chk("R9 flags in reset", 2'd1, 16'h0000);
    read_chk("R9 enable in reset", 2'd0, 16'h0000);
    read_chk("R9 master in reset", 2'd2, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule